// File: doc/BRIEF.md
# Prescaled Free-Running Timer with Periodic Interrupt

This block is a free-running up-counter that software can neither load nor stop. It advances only on cycles where the bus-clock enable `bus_en` is high, and a two-bit prescale select sets how many bus cycles pass between advances. Each advance is also driven onto a single-cycle `tick` output, so that other timer channels can run from the same time base. When the counter wraps from all ones to zero, an overflow flag is set. That flag drives an interrupt request when its enable bit is set.

A second divider, separate from the first, also counts bus cycles. It starts with a fixed power-of-two predivider and then applies a select of 1, 2, 4 or 8. At the end of each period it sets a periodic flag, which has its own interrupt enable. Software clears either flag by writing a 1 to its bit.

All access goes through a small register port. Writes are synchronous and reads are combinational. Address 0 returns the count and ignores writes. Address 1 is the control word. Address 2 holds the two flags, and writing a 1 to a flag bit clears it.

Top module: `tmr_free_core`

## Requirements
- R1: On each cycle where `tick` is high the count increases by one, wrapping to zero after its maximum value, and on every other cycle it holds. Writes to address 0 have no effect on it. Address 0 reads the count, zero-extended.
- R2: The prescale select sits in control bits [1:0]. The values 0, 1, 2 and 3 make the counter advance once every 1, 4, 8 and 16 bus cycles respectively.
- R3: The prescale select accepts writes only while fewer than LOCK_CYC bus cycles have passed since reset. After that, writes to bits [1:0] are ignored, while the other control bits still update.
- R4: Flag bit 0 at address 2 is the overflow flag. A wrap of the counter sets it. Writing 1 to bit 0 clears it, and writing 0 leaves it unchanged.
- R5: `irq_ovf` is high exactly when the overflow flag is set and control bit 4 is set.
- R6: The rate select sits in control bits [3:2]. With select r, a periodic event occurs once every 2^PRE_W * 2^r bus cycles, and the select may be changed at any time.
- R7: Flag bit 1 at address 2 is the periodic flag. It is set by each periodic event and cleared by writing 1 to bit 1. `irq_per` is that flag ANDed with control bit 5.
- R8: If a flag is set by hardware and cleared by software in the same cycle, it ends up set.
- R9: `tick` is a single-cycle pulse that occurs only when `bus_en` is high. While `bus_en` is low, neither the counter nor the prescaler advances.
- R10: After reset the count, the control word, both flags and both interrupt requests are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus-clock enable, one pulse per bus cycle |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| tick | output | 1 | One-cycle pulse on each counter advance |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_per | output | 1 | Periodic interrupt request |

## Verification
The bench builds the block with an 8-bit counter (CNT_W = 8) and a 4-bit predivider (PRE_W = 4), and keeps the lock window at 64 cycles. With these values the counter wraps within at most 4096 bus cycles, and the longest periodic interval is 128 cycles. This lets the bench sweep every prescale code and every rate code, each over a window that is an exact multiple of the period being measured. For each code, the number of ticks and of periodic events is computed arithmetically. The small counter also lets the bench line up a software clear on the exact wrap cycle to check that the set wins. Reaching the end of the lock window takes just one short wait.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned REG_W = 16;

  localparam logic [1:0] ADDR_COUNT = 2'd0;
  localparam logic [1:0] ADDR_CTRL  = 2'd1;
  localparam logic [1:0] ADDR_FLAGS = 2'd2;

  typedef struct packed {
    logic       per_en;
    logic       ovf_en;
    logic [1:0] rate;
    logic [1:0] psel;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  // Bus cycles per counter advance for a prescale code.
  function automatic int unsigned ps_factor(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 16;
    endcase
  endfunction

  // Low bits of the post divider that must be all ones at an event.
  function automatic logic [2:0] rate_mask(input logic [1:0] r);
    return (3'd1 << r) - 3'd1;
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int unsigned PS_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_en,
  input  logic [1:0] psel,
  output logic       tick
);

  logic [PS_W-1:0] pcnt;
  logic            hit;

  assign hit  = (pcnt >= PS_W'(ps_factor(psel) - 1));
  assign tick = bus_en && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (bus_en) begin
      pcnt <= hit ? '0 : pcnt + 1'b1;
    end
  end

  // R2: with a factor above one, two ticks never follow each other
  a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && psel != 2'd0) |=> (!tick || psel != $past(psel)));

  // R9: without a bus cycle the prescale count holds
  a_r9_hold_without_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> $stable(pcnt));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  assign wrap = tick && (&cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R1: each tick advances the count by one
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == $past(cnt) + 1'b1);

  // R1: without a tick the count holds
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

endmodule

// File: rtl/tmr_periodic.sv
module tmr_periodic
  import tmr_pkg::*;
#(
  parameter int unsigned PRE_W  = 13,
  parameter int unsigned POST_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_en,
  input  logic [1:0] rate,
  output logic       period
);

  logic [PRE_W-1:0]  pre;
  logic [POST_W-1:0] post;
  logic              pre_wrap;
  logic [2:0]        mask;

  assign pre_wrap = bus_en && (&pre);
  assign mask     = rate_mask(rate);
  assign period   = pre_wrap && ((post[2:0] & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre  <= '0;
      post <= '0;
    end else begin
      if (bus_en)   pre  <= pre + 1'b1;
      if (pre_wrap) post <= post + 1'b1;
    end
  end

  // R6: events are at least a full predivider apart
  a_r6_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    period |=> !period);

  // R6: the post divider moves only at the end of a predivider pass
  a_r6_post_moves_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_wrap |=> $stable(post));

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  // R8: a hardware set is never lost to a clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);

  // R4: a clear without a set empties the flag
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);

  // R4: without a clear the flag never falls
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr) |=> q);

endmodule

// File: rtl/tmr_free_core.sv
module tmr_free_core
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PRE_W    = 13,
  parameter int unsigned LOCK_CYC = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        tick,
  output logic        irq_ovf,
  output logic        irq_per
);

  localparam int unsigned PS_W = 4;
  localparam int unsigned LW   = $clog2(LOCK_CYC + 1);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] cnt;
  logic             cnt_wrap;
  logic             per_event;
  logic             ovf_flag;
  logic             per_flag;
  logic [LW-1:0]    lcnt;
  logic             locked;
  logic             wr_ctrl;
  logic             wr_flags;
  logic             ovf_clr;
  logic             per_clr;

  assign locked   = (lcnt == LW'(LOCK_CYC));
  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_flags = bus_wr && (bus_addr == ADDR_FLAGS);
  assign ovf_clr  = wr_flags && bus_wdata[0];
  assign per_clr  = wr_flags && bus_wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcnt <= '0;
    end else if (bus_en && !locked) begin
      lcnt <= lcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_ctrl) begin
      ctrl.per_en <= bus_wdata[5];
      ctrl.ovf_en <= bus_wdata[4];
      ctrl.rate   <= bus_wdata[3:2];
      if (!locked) ctrl.psel <= bus_wdata[1:0];
    end
  end

  tmr_prescaler #(.PS_W(PS_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .psel(ctrl.psel), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .wrap(cnt_wrap)
  );

  tmr_periodic #(.PRE_W(PRE_W), .POST_W(3)) u_per (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .rate(ctrl.rate), .period(per_event)
  );

  tmr_flag u_ovf_flag (
    .clk(clk), .rst_n(rst_n), .set(cnt_wrap), .clr(ovf_clr), .q(ovf_flag)
  );

  tmr_flag u_per_flag (
    .clk(clk), .rst_n(rst_n), .set(per_event), .clr(per_clr), .q(per_flag)
  );

  assign irq_ovf = ovf_flag && ctrl.ovf_en;
  assign irq_per = per_flag && ctrl.per_en;

  always_comb begin
    case (bus_addr)
      ADDR_COUNT: bus_rdata = REG_W'(cnt);
      ADDR_CTRL:  bus_rdata = REG_W'(ctrl);
      ADDR_FLAGS: bus_rdata = {14'd0, per_flag, ovf_flag};
      default:    bus_rdata = '0;
    endcase
  end

  // R3: once the window closes the prescale select is frozen
  a_r3_locked_psel: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(ctrl.psel));

  // R4: a wrap of the counter leaves the overflow flag set
  a_r4_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wrap |=> (ovf_flag && cnt == '0));

  // R5: no overflow request without its enable
  a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_ovf) |-> ctrl.ovf_en);

  // R7: no periodic request without its enable
  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_per) |-> ctrl.per_en);

  // R9: a tick is only ever produced on a bus cycle
  a_r9_tick_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> bus_en);

endmodule

// File: tb/sim_tmr_free_core.sv
module sim_tmr_free_core;

  localparam int CLK_P    = 10;
  localparam int CNT_W    = 8;
  localparam int PRE_W    = 4;
  localparam int LOCK_CYC = 64;
  localparam int CMAX     = (1 << CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b1;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        tick, irq_ovf, irq_per;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  tmr_free_core #(.CNT_W(CNT_W), .PRE_W(PRE_W), .LOCK_CYC(LOCK_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick(tick), .irq_ovf(irq_ovf), .irq_per(irq_per)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0; bus_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    bus_addr = a; bus_wdata = 16'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  // Ticks over n consecutive cycles and the count moved meanwhile.
  task automatic measure(input int n, output int ticks, output int delta);
    int c0, c1;
    rd(2'd0, c0);
    ticks = 0;
    for (int i = 0; i < n; i++) begin
      if (tick) ticks++;
      @(negedge clk); #1;
    end
    rd(2'd0, c1);
    delta = (c1 - c0) & CMAX;
  endtask

  task automatic wait_wrap_edge(output bit found);
    int c;
    found = 1'b0;
    for (int k = 0; k < 600; k++) begin
      rd(2'd0, c);
      if (tick && c == CMAX) begin
        found = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog got=hung expected=finished");
      finish_up();
    end
  end

  initial begin
    int v, t, d, n, c0, c1;
    bit found;
    int expf [4] = '{1, 4, 8, 16};

    // R10: reset state
    do_reset();
    rd(2'd0, v); check("R10 count", v, 0);
    rd(2'd1, v); check("R10 ctrl", v, 0);
    rd(2'd2, v); check("R10 flags", v, 0);
    check("R10 irq_ovf", int'(irq_ovf), 0);
    check("R10 irq_per", int'(irq_per), 0);

    // R2 sweep over every prescale code, R1 count follows ticks
    for (int s = 0; s < 4; s++) begin
      do_reset();
      wr(2'd1, s);
      rd(2'd1, v); check("R2 psel readback", v & 3, s);
      measure(64, t, d);
      check("R2 ticks per 64 cycles", t, 64 / expf[s]);
      check("R1 count delta equals ticks", d, t & CMAX);
    end

    // R1: writes to the count are ignored (factor 1, one advance per cycle)
    do_reset();
    @(negedge clk); #1;
    rd(2'd0, c0);
    bus_addr = 2'd0; bus_wdata = 16'h0055; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; #1;
    rd(2'd0, c1);
    check("R1 write to count ignored", c1, (c0 + 1) & CMAX);

    // R9: no bus cycles, nothing moves
    bus_en = 1'b0;
    rd(2'd0, c0);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      if (tick) n++;
      @(negedge clk); #1;
    end
    rd(2'd0, c1);
    check("R9 no tick without bus_en", n, 0);
    check("R9 count holds without bus_en", c1, c0);
    bus_en = 1'b1;

    // R3: write inside the window takes effect
    do_reset();
    repeat (50) @(negedge clk);
    wr(2'd1, 2);
    rd(2'd1, v); check("R3 write inside window", v & 3, 2);
    // R3: after the window the select is frozen but other bits update
    do_reset();
    repeat (LOCK_CYC + 10) @(negedge clk);
    wr(2'd1, 32'h13);
    rd(2'd1, v);
    check("R3 psel frozen after window", v & 3, 0);
    check("R3 other bits still written", v & 32'h10, 32'h10);
    measure(64, t, d);
    check("R3 rate unchanged after late write", t, 64);

    // R4/R5: overflow with enable off, then on
    do_reset();
    wait_wrap_edge(found);
    check("R4 wrap reached", int'(found), 1);
    @(negedge clk); #1;
    rd(2'd0, v); check("R1 wrap to zero", v, 0);
    rd(2'd2, v); check("R4 flag set on wrap", v & 1, 1);
    check("R5 irq gated off", int'(irq_ovf), 0);
    wr(2'd1, 32'h10);
    check("R5 irq with enable", int'(irq_ovf), 1);
    wr(2'd2, 0);
    rd(2'd2, v); check("R4 write 0 keeps flag", v & 1, 1);
    wr(2'd2, 1);
    rd(2'd2, v); check("R4 write 1 clears flag", v & 1, 0);
    check("R5 irq drops with flag", int'(irq_ovf), 0);

    // R8: clear on the exact wrap cycle loses to the set
    wait_wrap_edge(found);
    check("R8 wrap reached", int'(found), 1);
    bus_addr = 2'd2; bus_wdata = 16'd1; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; #1;
    rd(2'd2, v); check("R8 set wins over clear", v & 1, 1);

    // R6/R7: rate sweep without reset, select changed on the fly
    do_reset();
    begin
      int order [4] = '{3, 0, 2, 1};
      for (int j = 0; j < 4; j++) begin
        int r, per;
        bit irq_seen;
        r = order[j];
        per = (1 << PRE_W) << r;
        wr(2'd1, 32'h20 | (r << 2));
        repeat (144) @(negedge clk);
        wr(2'd2, 2);
        n = 0; irq_seen = 1'b0;
        bus_addr = 2'd2;
        for (int i = 0; i < 512; i++) begin
          #1;
          if (bus_rdata[1]) begin
            n++;
            if (irq_per) irq_seen = 1'b1;
            bus_wdata = 16'd2; bus_wr = 1'b1;
          end else begin
            bus_wr = 1'b0;
          end
          @(negedge clk);
        end
        bus_wr = 1'b0;
        check("R6 periodic events per 512 cycles", n, 512 / per);
        check("R7 irq_per raised with enable", int'(irq_seen), 1);
      end
    end

    // R7: periodic flag sets but request stays low when disabled
    wr(2'd1, 0);
    wr(2'd2, 2);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      if (irq_per) n++;
      @(negedge clk); #1;
    end
    rd(2'd2, v);
    check("R7 flag sets while disabled", (v >> 1) & 1, 1);
    check("R7 no request while disabled", n, 0);
    wr(2'd2, 2);
    rd(2'd2, v); check("R7 write 1 clears periodic flag", (v >> 1) & 1, 0);

    done = 1'b1;
    finish_up();
  end

endmodule